// File: doc/BRIEF.md
# Completion Packet Stream Formatter

This block turns one read completion at a time into a single AXI4-Stream packet. A completion is made of a three-Dword descriptor and a payload of 1 to `MAX_DW` Dwords. The upstream side presents the descriptor together with the placement and byte-enable information. It then streams the payload Dwords one per handshake into an internal buffer. Once the whole payload is held, the block emits the packet on a `DATA_W`-bit bus (64, 128 or 256). Each beat carries one `tkeep` bit per Dword lane, `tlast` on the final beat, and a `tuser` word holding a start-of-packet flag and per-byte payload enables.

Two placement modes are supported. In packed mode the payload follows the descriptor Dwords directly, in the same beat where room remains. In aligned mode the payload begins on the first beat after the one that holds the last descriptor Dword. Its first Dword sits at lane `offset mod (DATA_W/32)`. Byte enables are built from the completion's byte offset and byte count when the payload is longer than two Dwords. For short payloads they are built from the request's first and last enable masks. A zero-length read still produces one payload Dword, with no bytes enabled.

Top module: `cpl_stream_fmt`

## Requirements
- R1: The first three Dword slots of every packet carry the descriptor: `cpl_desc_i[31:0]` in slot 0, `[63:32]` in slot 1 and `[95:64]` in slot 2. Slot s is lane `s mod (DATA_W/32)` of beat `s div (DATA_W/32)`, and lane j is `m_tdata_o[32*j +: 32]`.
- R2: When `cpl_align_i`=0, payload Dword k occupies slot 3+k.
- R3: When `cpl_align_i`=1, payload Dword k occupies slot `H + (cpl_addr_ofs_i mod (DATA_W/32)) + k`. H is the descriptor slot count 3 rounded up to a whole beat. Slots between the descriptor and the payload carry zero data.
- R4: `m_tvalid_o` is low after reset and stays high from the first beat until the `tlast` handshake. While `m_tready_i` is low, data, keep, last and user hold their values.
- R5: `m_tkeep_o` bit j covers lane j. It is set contiguously from slot 0 through the last payload slot, padding slots included. Only the final beat may hold zeros.
- R6: `m_tlast_o` is high only on the final beat. `m_tuser_o[0]` (start of packet) is high only on the first beat.
- R7: Byte-enable bit `m_tuser_o[1+4*j+b]` covers byte b of lane j. It is never high for a descriptor or padding lane.
- R8: For more than two payload Dwords, the enabled payload bytes run contiguously. They start at byte index `cpl_addr_lo_i` of Dword 0 and end at byte index `(cpl_addr_lo_i + cpl_bcnt_lo_i - 1) mod 4` of the last Dword.
- R9: For one payload Dword the enables equal `cpl_first_be_i`. For two Dwords, Dword 0 takes `cpl_first_be_i` and Dword 1 takes `cpl_last_be_i`; the result may be non-contiguous.
- R10: With `cpl_zero_len_i`=1 the packet carries exactly one payload Dword and all its byte enables are zero.
- R11: `cpl_ready_o` is high only while idle and `pl_ready_o` only while the payload is being loaded. Neither is high while a packet is on the output.
- R12: Byte-enable bits at or above `DATA_W/8` in `m_tuser_o[32:1]` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpl_valid_i | input | 1 | Completion header valid |
| cpl_ready_o | output | 1 | Header accepted when high with valid |
| cpl_desc_i | input | 96 | Descriptor Dwords 0..2 |
| cpl_len_i | input | $clog2(MAX_DW+1) | Payload length in Dwords (1..MAX_DW) |
| cpl_addr_lo_i | input | 2 | Byte offset of first payload byte (lower address bits 1:0) |
| cpl_bcnt_lo_i | input | 2 | Byte count modulo 4 |
| cpl_first_be_i | input | 4 | First-Dword enable mask of the request |
| cpl_last_be_i | input | 4 | Last-Dword enable mask of the request |
| cpl_zero_len_i | input | 1 | Zero-length read completion |
| cpl_align_i | input | 1 | 0 packed placement, 1 aligned placement |
| cpl_addr_ofs_i | input | 3 | Dword offset for aligned placement |
| pl_valid_i | input | 1 | Payload Dword valid |
| pl_ready_o | output | 1 | Payload Dword accepted |
| pl_data_i | input | 32 | Payload Dword |
| m_tvalid_o | output | 1 | Stream valid |
| m_tready_i | input | 1 | Stream ready |
| m_tdata_o | output | DATA_W | Stream data |
| m_tkeep_o | output | DATA_W/32 | Per-Dword keep |
| m_tlast_o | output | 1 | Final beat |
| m_tuser_o | output | 33 | Bit 0 start of packet, bits 32:1 byte enables |

## Verification
The hardest placement to reach is the aligned mode with an offset larger than the lane count. The offset must wrap onto a lower lane and still leave padding slots that are kept but carry no enables. The stimulus sends an offset of 6 on a four-lane bus and checks that the payload starts at lane 2 of the second beat. A second hard case is holding the output under backpressure. One scenario pulls ready low for two cycles on every beat of a multi-beat aligned packet and compares each held beat with its first sample.

// File: rtl/cpl_fmt_pkg.sv
package cpl_fmt_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LOAD,
    ST_SEND
  } fmt_state_e;

  // byte enables of payload Dword k in a payload of n Dwords
  function automatic logic [3:0] pl_byte_en(
    input logic [7:0] k,
    input logic [7:0] n,
    input logic       zero,
    input logic [1:0] addr_lo,
    input logic [1:0] bcnt_lo,
    input logic [3:0] first_be,
    input logic [3:0] last_be
  );
    logic [1:0] end_b;
    end_b = addr_lo + bcnt_lo - 2'd1;
    if (zero)                  return 4'h0;
    else if (n == 8'd1)        return first_be;
    else if (n == 8'd2)        return (k == 8'd0) ? first_be : last_be;
    else if (k == 8'd0)        return 4'hF << addr_lo;
    else if (k == n - 8'd1)    return 4'hF >> (2'd3 - end_b);
    else                       return 4'hF;
  endfunction

endpackage

// File: rtl/cpl_fmt_pl_buf.sv
module cpl_fmt_pl_buf #(
  parameter int MAX_DW = 32,
  parameter int NRD    = 4,
  localparam int IDX_W = $clog2(MAX_DW)
) (
  input  logic                       clk_i,
  input  logic                       we_i,
  input  logic [IDX_W-1:0]           waddr_i,
  input  logic [31:0]                wdata_i,
  input  logic [NRD-1:0][IDX_W-1:0]  rd_idx_i,
  output logic [NRD-1:0][31:0]       rd_data_o
);

  logic [31:0] mem_q [MAX_DW];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  for (genvar i = 0; i < NRD; i++) begin : g_rd
    assign rd_data_o[i] = mem_q[rd_idx_i[i]];
  end

endmodule

// File: rtl/cpl_fmt_lane.sv
module cpl_fmt_lane
  import cpl_fmt_pkg::*;
#(
  parameter int POS_W = 6,
  parameter int LEN_W = 6,
  parameter int IDX_W = 5
) (
  input  logic [POS_W-1:0] pos_i,
  input  logic [POS_W-1:0] start_i,
  input  logic [POS_W-1:0] total_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic [95:0]      desc_i,
  input  logic             zero_i,
  input  logic [1:0]       addr_lo_i,
  input  logic [1:0]       bcnt_lo_i,
  input  logic [3:0]       first_be_i,
  input  logic [3:0]       last_be_i,
  output logic [IDX_W-1:0] rd_idx_o,
  input  logic [31:0]      rd_data_i,
  output logic [31:0]      data_o,
  output logic             keep_o,
  output logic [3:0]       be_o
);

  logic             in_pl;
  logic [POS_W-1:0] k;

  assign k        = pos_i - start_i;
  assign in_pl    = (pos_i >= start_i) && (pos_i < total_i);
  assign rd_idx_o = k[IDX_W-1:0];
  assign keep_o   = pos_i < total_i;

  always_comb begin
    data_o = '0;
    if (pos_i == POS_W'(0))      data_o = desc_i[31:0];
    else if (pos_i == POS_W'(1)) data_o = desc_i[63:32];
    else if (pos_i == POS_W'(2)) data_o = desc_i[95:64];
    else if (in_pl)              data_o = rd_data_i;
  end

  assign be_o = in_pl ? pl_byte_en(8'(k), 8'(len_i), zero_i, addr_lo_i, bcnt_lo_i,
                                   first_be_i, last_be_i)
                      : 4'h0;

endmodule

// File: rtl/cpl_stream_fmt.sv
module cpl_stream_fmt
  import cpl_fmt_pkg::*;
#(
  parameter int DATA_W = 128,
  parameter int MAX_DW = 32,
  localparam int NDW   = DATA_W / 32,
  localparam int BE_W  = DATA_W / 8,
  localparam int LEN_W = $clog2(MAX_DW + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cpl_valid_i,
  output logic              cpl_ready_o,
  input  logic [95:0]       cpl_desc_i,
  input  logic [LEN_W-1:0]  cpl_len_i,
  input  logic [1:0]        cpl_addr_lo_i,
  input  logic [1:0]        cpl_bcnt_lo_i,
  input  logic [3:0]        cpl_first_be_i,
  input  logic [3:0]        cpl_last_be_i,
  input  logic              cpl_zero_len_i,
  input  logic              cpl_align_i,
  input  logic [2:0]        cpl_addr_ofs_i,
  input  logic              pl_valid_i,
  output logic              pl_ready_o,
  input  logic [31:0]       pl_data_i,
  output logic              m_tvalid_o,
  input  logic              m_tready_i,
  output logic [DATA_W-1:0] m_tdata_o,
  output logic [NDW-1:0]    m_tkeep_o,
  output logic              m_tlast_o,
  output logic [32:0]       m_tuser_o
);

  localparam int IDX_W     = $clog2(MAX_DW);
  localparam int POS_W     = $clog2(MAX_DW + 2 * NDW + 16);
  localparam int HDR_SLOTS = ((3 + NDW - 1) / NDW) * NDW;
  localparam int DESC_BE_W = (NDW < 3) ? 4 * NDW : 12;

  fmt_state_e       state_q;
  logic [95:0]      desc_q;
  logic [LEN_W-1:0] len_q, wr_cnt_q, acc_len;
  logic [POS_W-1:0] start_q, total_q, beat_q, acc_start, base_pos;
  logic [POS_W:0]   beat_end;
  logic [1:0]       addr_lo_q, bcnt_lo_q;
  logic [3:0]       first_be_q, last_be_q;
  logic             zero_q, last_beat;

  assign cpl_ready_o = (state_q == ST_IDLE);
  assign pl_ready_o  = (state_q == ST_LOAD);
  assign m_tvalid_o  = (state_q == ST_SEND);

  assign acc_len   = (cpl_zero_len_i || cpl_len_i == '0) ? LEN_W'(1) : cpl_len_i;
  assign acc_start = cpl_align_i
                   ? POS_W'(HDR_SLOTS) + (POS_W'(cpl_addr_ofs_i) % POS_W'(NDW))
                   : POS_W'(3);

  assign base_pos  = POS_W'(beat_q * POS_W'(NDW));
  assign beat_end  = {1'b0, base_pos} + (POS_W + 1)'(NDW);
  assign last_beat = beat_end >= {1'b0, total_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      desc_q     <= '0;
      len_q      <= '0;
      wr_cnt_q   <= '0;
      start_q    <= '0;
      total_q    <= '0;
      beat_q     <= '0;
      addr_lo_q  <= '0;
      bcnt_lo_q  <= '0;
      first_be_q <= '0;
      last_be_q  <= '0;
      zero_q     <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (cpl_valid_i) begin
          desc_q     <= cpl_desc_i;
          len_q      <= acc_len;
          start_q    <= acc_start;
          total_q    <= acc_start + POS_W'(acc_len);
          addr_lo_q  <= cpl_addr_lo_i;
          bcnt_lo_q  <= cpl_bcnt_lo_i;
          first_be_q <= cpl_first_be_i;
          last_be_q  <= cpl_last_be_i;
          zero_q     <= cpl_zero_len_i;
          wr_cnt_q   <= '0;
          state_q    <= ST_LOAD;
        end
        ST_LOAD: if (pl_valid_i) begin
          wr_cnt_q <= wr_cnt_q + 1'b1;
          if (wr_cnt_q == len_q - 1'b1) begin
            beat_q  <= '0;
            state_q <= ST_SEND;
          end
        end
        ST_SEND: if (m_tready_i) begin
          if (last_beat) state_q <= ST_IDLE;
          else           beat_q  <= beat_q + 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  logic [NDW-1:0][IDX_W-1:0] rd_idx;
  logic [NDW-1:0][31:0]      rd_data;
  logic [BE_W-1:0]           be_all;

  cpl_fmt_pl_buf #(.MAX_DW(MAX_DW), .NRD(NDW)) u_buf (
    .clk_i     (clk_i),
    .we_i      (pl_valid_i && pl_ready_o),
    .waddr_i   (wr_cnt_q[IDX_W-1:0]),
    .wdata_i   (pl_data_i),
    .rd_idx_i  (rd_idx),
    .rd_data_o (rd_data)
  );

  for (genvar j = 0; j < NDW; j++) begin : g_lane
    cpl_fmt_lane #(.POS_W(POS_W), .LEN_W(LEN_W), .IDX_W(IDX_W)) u_lane (
      .pos_i      (base_pos + POS_W'(j)),
      .start_i    (start_q),
      .total_i    (total_q),
      .len_i      (len_q),
      .desc_i     (desc_q),
      .zero_i     (zero_q),
      .addr_lo_i  (addr_lo_q),
      .bcnt_lo_i  (bcnt_lo_q),
      .first_be_i (first_be_q),
      .last_be_i  (last_be_q),
      .rd_idx_o   (rd_idx[j]),
      .rd_data_i  (rd_data[j]),
      .data_o     (m_tdata_o[32*j +: 32]),
      .keep_o     (m_tkeep_o[j]),
      .be_o       (be_all[4*j +: 4])
    );

    // enabled bytes only in kept lanes
    p_be_in_keep_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      m_tvalid_o && (m_tuser_o[1+4*j +: 4] != 4'h0) |-> m_tkeep_o[j]);
  end

  assign m_tlast_o = m_tvalid_o && last_beat;
  assign m_tuser_o = {32'(be_all), m_tvalid_o && (beat_q == '0)};

  p_stall_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    m_tvalid_o && !m_tready_i |=> m_tvalid_o && $stable(m_tdata_o) &&
      $stable(m_tkeep_o) && $stable(m_tlast_o) && $stable(m_tuser_o));

  p_valid_to_last_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    m_tvalid_o && m_tready_i && !m_tlast_o |=> m_tvalid_o);

  p_keep_full_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    m_tvalid_o && !m_tlast_o |-> &m_tkeep_o);

  p_keep_contig_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    m_tvalid_o |-> m_tkeep_o[0] && ((m_tkeep_o & (m_tkeep_o + 1'b1)) == '0));

  p_sof_first_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(m_tvalid_o) |-> m_tuser_o[0]);

  p_sof_once_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    m_tvalid_o && m_tready_i && !m_tlast_o |=> !m_tuser_o[0]);

  p_desc_no_be_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    m_tvalid_o && m_tuser_o[0] |-> m_tuser_o[DESC_BE_W:1] == '0);

  p_no_accept_busy_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    m_tvalid_o |-> !cpl_ready_o && !pl_ready_o);

  if (BE_W < 32) begin : g_upper
    p_be_upper_zero_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
      m_tuser_o[32:BE_W+1] == '0);
  end

endmodule

// File: tb/cpl_stream_fmt_bench.sv
module cpl_stream_fmt_bench;

  localparam int DATA_W     = 128;
  localparam int MAX_DW     = 32;
  localparam int NDW        = DATA_W / 32;
  localparam int BE_W       = DATA_W / 8;
  localparam int LEN_W      = $clog2(MAX_DW + 1);
  localparam int CLK_PERIOD = 10;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              cpl_valid_i = 1'b0;
  logic              cpl_ready_o;
  logic [95:0]       cpl_desc_i = '0;
  logic [LEN_W-1:0]  cpl_len_i = '0;
  logic [1:0]        cpl_addr_lo_i = '0;
  logic [1:0]        cpl_bcnt_lo_i = '0;
  logic [3:0]        cpl_first_be_i = '0;
  logic [3:0]        cpl_last_be_i = '0;
  logic              cpl_zero_len_i = 1'b0;
  logic              cpl_align_i = 1'b0;
  logic [2:0]        cpl_addr_ofs_i = '0;
  logic              pl_valid_i = 1'b0;
  logic              pl_ready_o;
  logic [31:0]       pl_data_i = '0;
  logic              m_tvalid_o;
  logic              m_tready_i = 1'b1;
  logic [DATA_W-1:0] m_tdata_o;
  logic [NDW-1:0]    m_tkeep_o;
  logic              m_tlast_o;
  logic [32:0]       m_tuser_o;

  int n_chk  = 0;
  int n_fail = 0;
  int tid    = 0;

  always #(CLK_PERIOD / 2) clk_i = ~clk_i;

  cpl_stream_fmt #(.DATA_W(DATA_W), .MAX_DW(MAX_DW)) u_cpl_stream_fmt (.*);

  task automatic chk(input string tag, input string what,
                     input logic [255:0] act, input logic [255:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_be(input int k, input int nn, input bit zero,
                                        input logic [1:0] alo, input int bcnt,
                                        input logic [3:0] fbe, input logic [3:0] lbe);
    logic [3:0] r;
    int first_b, last_b;
    if (zero) return 4'h0;
    if (nn == 1) return fbe;
    if (nn == 2) return (k == 0) ? fbe : lbe;
    first_b = int'(alo);
    last_b  = int'(alo) + bcnt - 1;
    for (int i = 0; i < 4; i++) r[i] = (4*k + i >= first_b) && (4*k + i <= last_b);
    return r;
  endfunction

  task automatic run_cpl(input bit mode, input logic [2:0] ofs, input int n,
                         input logic [1:0] alo, input int bcnt,
                         input logic [3:0] fbe, input logic [3:0] lbe,
                         input bit zero, input bit stall,
                         input string ptag, input string btag);
    logic [31:0] desc [3];
    logic [31:0] pay [MAX_DW];
    int nn, s, tot, nb;
    tid++;
    nn  = zero ? 1 : n;
    s   = mode ? (((3 + NDW - 1) / NDW) * NDW + (int'(ofs) % NDW)) : 3;
    tot = s + nn;
    nb  = (tot + NDW - 1) / NDW;
    for (int i = 0; i < 3; i++) desc[i] = 32'hD500_0000 + (tid << 8) + i;
    for (int k = 0; k < nn; k++) pay[k] = 32'h7A00_0000 + (tid << 12) + k;

    @(negedge clk_i);
    cpl_valid_i    = 1'b1;
    cpl_desc_i     = {desc[2], desc[1], desc[0]};
    cpl_len_i      = LEN_W'(zero ? 0 : n);
    cpl_addr_lo_i  = alo;
    cpl_bcnt_lo_i  = 2'(bcnt);
    cpl_first_be_i = fbe;
    cpl_last_be_i  = lbe;
    cpl_zero_len_i = zero;
    cpl_align_i    = mode;
    cpl_addr_ofs_i = ofs;
    while (!cpl_ready_o) @(negedge clk_i);
    @(negedge clk_i);
    cpl_valid_i = 1'b0;
    for (int k = 0; k < nn; k++) begin
      pl_valid_i = 1'b1;
      pl_data_i  = pay[k];
      while (!pl_ready_o) @(negedge clk_i);
      @(negedge clk_i);
    end
    pl_valid_i = 1'b0;

    for (int b = 0; b < nb; b++) begin
      logic [DATA_W-1:0] ed;
      logic [NDW-1:0]    ek;
      logic [31:0]       ebv;
      logic [DATA_W-1:0] snap_d;
      logic [32:0]       snap_u;
      ed = '0; ek = '0; ebv = '0;
      for (int j = 0; j < NDW; j++) begin
        int pos;
        pos = b * NDW + j;
        if (pos < 3) ed[32*j +: 32] = desc[pos];
        else if (pos >= s && pos < tot) begin
          ed[32*j +: 32] = pay[pos - s];
          ebv[4*j +: 4]  = exp_be(pos - s, nn, zero, alo, bcnt, fbe, lbe);
        end
        ek[j] = pos < tot;
      end
      if (stall) begin
        m_tready_i = 1'b0;
        snap_d = m_tdata_o;
        snap_u = m_tuser_o;
        repeat (2) @(negedge clk_i);
        chk("R4", "held data", 256'(m_tdata_o), 256'(snap_d));
        chk("R4", "held user", 256'(m_tuser_o), 256'(snap_u));
        m_tready_i = 1'b1;
      end
      chk("R4", "valid", 256'(m_tvalid_o), 256'(1));
      chk("R11", "ready while busy", 256'({cpl_ready_o, pl_ready_o}), 256'(0));
      chk(ptag, "data", 256'(m_tdata_o), 256'(ed));
      chk("R5", "keep", 256'(m_tkeep_o), 256'(ek));
      chk("R6", "last", 256'(m_tlast_o), 256'(b == nb - 1));
      chk("R6", "sof", 256'(m_tuser_o[0]), 256'(b == 0));
      chk(btag, "byte en", 256'(m_tuser_o[32:1]), 256'(ebv));
      if (BE_W < 32) chk("R12", "upper en", 256'(m_tuser_o[32:1] >> BE_W), 256'(0));
      @(negedge clk_i);
    end
    chk("R6", "valid after last", 256'(m_tvalid_o), 256'(0));
  endtask

  task automatic t_reset();
    chk("R4", "valid at reset", 256'(m_tvalid_o), 256'(0));
    chk("R11", "header ready at reset", 256'(cpl_ready_o), 256'(1));
    chk("R11", "payload ready at reset", 256'(pl_ready_o), 256'(0));
  endtask

  task automatic t_packed_long();     // R1 R2 R8: 6 Dwords, byte offset 0
    run_cpl(1'b0, 3'd0, 6, 2'd0, 24, 4'h0, 4'h0, 1'b0, 1'b0, "R2", "R8");
  endtask

  task automatic t_packed_ragged();   // R8: first Dword from byte 2, last ends at byte 2
    run_cpl(1'b0, 3'd0, 5, 2'd2, 17, 4'h0, 4'h0, 1'b0, 1'b0, "R1", "R8");
  endtask

  task automatic t_aligned_ofs1();    // R3: payload at lane 1 of beat 1
    run_cpl(1'b1, 3'd1, 4, 2'd0, 16, 4'h0, 4'h0, 1'b0, 1'b0, "R3", "R8");
  endtask

  task automatic t_aligned_wrap();    // R3: offset 6 wraps onto lane 2
    run_cpl(1'b1, 3'd6, 3, 2'd3, 7, 4'h0, 4'h0, 1'b0, 1'b0, "R3", "R7");
  endtask

  task automatic t_two_dw();          // R9: non-contiguous masks
    run_cpl(1'b0, 3'd0, 2, 2'd0, 5, 4'b0001, 4'b1000, 1'b0, 1'b0, "R2", "R9");
  endtask

  task automatic t_one_dw();          // R9: single Dword uses first mask
    run_cpl(1'b1, 3'd3, 1, 2'd1, 2, 4'b0110, 4'b0000, 1'b0, 1'b0, "R3", "R9");
  endtask

  task automatic t_zero_len();        // R10
    run_cpl(1'b0, 3'd0, 0, 2'd0, 1, 4'b1111, 4'b0000, 1'b1, 1'b0, "R10", "R10");
  endtask

  task automatic t_stall();           // R4: backpressure on every beat
    run_cpl(1'b1, 3'd3, 7, 2'd0, 28, 4'h0, 4'h0, 1'b0, 1'b1, "R3", "R8");
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_packed_long();
    t_packed_ragged();
    t_aligned_ofs1();
    t_aligned_wrap();
    t_two_dw();
    t_one_dw();
    t_zero_len();
    t_stall();
    t_packed_long();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

endmodule